// File: doc/BRIEF.md
# Programmable Interval and Compare Timer Channel

This block is a single timer channel for an operating-system tick source. Software reaches it through a small register bank on a plain memory-mapped write port with a combinational read port. It holds a compare value and a mode bit, and it counts on an external count-enable input, which an upstream prescaler supplies.

Two write-only trigger registers control the channel: one starts it and one stops it. A read-only status register shows whether the channel is running, so software can poll it after a stop. In interval mode the counter is loaded from the compare value, counts down and reloads, and it pulses the interrupt once every compare+1 enabled ticks. In free-running mode the counter starts at zero and counts up through its whole range, wrapping at the top. The interrupt pulses on the tick that brings the count equal to the compare value. The compare value and the mode bit are copied into the running channel only when it is started. Software therefore reprograms them while stopped, or writes them early and restarts.

Top module: `tick_timer`

## Requirements
- R1: After reset, the compare, count, status and mode registers all read 0, the channel is stopped and `irq` is low.
- R2: A write to offset 0x14 with data bit 0 at 1 starts the channel, and bit 0 of offset 0x10 then reads 1. The same write with bit 0 at 0 has no effect. A start issued while running restarts the channel.
- R3: A write to offset 0x18 with data bit 0 at 1 stops the channel. Bit 0 of offset 0x10 then reads 0, and the count at offset 0x04 holds its last value.
- R4: With mode bit 1 of offset 0x20 at 0 (interval mode), a start loads the count with the compare value from offset 0x00. Each enabled tick then decrements the count by one.
- R5: In interval mode, an enabled tick that finds the count at zero reloads the compare value and drives `irq` high for the following cycle. The interrupt therefore recurs every compare+1 enabled ticks, and the channel keeps running.
- R6: With mode bit 1 at 1 (free-running mode), a start clears the count to zero. Each enabled tick then increments the count by one.
- R7: In free-running mode, `irq` is high for one cycle after the tick that makes the count equal to the compare value. Counting continues, and the count wraps from its all-ones value to zero.
- R8: While `tickEn` is low, the count does not change and no interrupt is raised.
- R9: Writes to the compare and mode registers read back at once. The running channel keeps its period and mode until the next start.
- R10: Only bit 1 of the mode register is stored; its other bits read 0. The compare register keeps CNT_W bits. Reads of the trigger offsets 0x14 and 0x18, and of unmapped offsets, return 0.
- R11: `irq` stays low while the channel is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte offset of the register access |
| busWrite | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| tickEn | input | 1 | Count enable from the prescaler |
| irq | output | 1 | Interrupt pulse |

## Verification
The hardest event to reach from the ports is the free-running wrap. With a full-width counter it needs about four billion ticks. The bench therefore builds the block with a 16-bit counter, holds the count enable high for 65 542 ticks after a start, and expects exactly two interrupts and a final count of 6. A second condition that random stimulus seldom produces is a compare and mode rewrite during an active interval period. A directed step handles it: it rewrites both while the channel is running and checks that the interrupt spacing is unchanged until the restart.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // register byte offsets (software-visible map)
  localparam int OFS_LIMIT  = 'h00;
  localparam int OFS_COUNT  = 'h04;
  localparam int OFS_STATUS = 'h10;
  localparam int OFS_START  = 'h14;
  localparam int OFS_STOP   = 'h18;
  localparam int OFS_MODE   = 'h20;

  // bit positions inside the 8-bit control registers
  localparam int TRIG_BIT = 0;
  localparam int MODE_BIT = 1;

  // control -> datapath strobes
  typedef struct packed {
    logic startPulse;  // load counter this cycle
    logic advance;     // count one tick this cycle
    logic freeMode;    // 1: up-count with compare, 0: down-count with reload
  } strobe_t;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              tickEn,
  input  logic [CNT_W-1:0]  countIn,
  output strobe_t           st,
  output logic [CNT_W-1:0]  limitOut
);

  logic [CNT_W-1:0] cmpReg;
  logic             modeReg;
  logic             runReg;
  logic [CNT_W-1:0] activeLimit;
  logic             activeFree;

  logic hitLimit, hitMode, startHit, stopHit;

  always_comb begin
    hitLimit = busWrite && (busAddr == ADDR_W'(OFS_LIMIT));
    hitMode  = busWrite && (busAddr == ADDR_W'(OFS_MODE));
    startHit = busWrite && (busAddr == ADDR_W'(OFS_START)) && busWdata[TRIG_BIT];
    stopHit  = busWrite && (busAddr == ADDR_W'(OFS_STOP))  && busWdata[TRIG_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpReg      <= '0;
      modeReg     <= 1'b0;
      runReg      <= 1'b0;
      activeLimit <= '0;
      activeFree  <= 1'b0;
    end else begin
      if (hitLimit) cmpReg  <= busWdata[CNT_W-1:0];
      if (hitMode)  modeReg <= busWdata[MODE_BIT];
      if (startHit) begin
        runReg      <= 1'b1;
        activeLimit <= cmpReg;
        activeFree  <= modeReg;
      end else if (stopHit) begin
        runReg <= 1'b0;
      end
    end
  end

  // strobes: a start takes the programmed values straight from the registers
  always_comb begin
    st.startPulse = startHit;
    st.advance    = runReg && tickEn && !stopHit && !startHit;
    st.freeMode   = startHit ? modeReg : activeFree;
    limitOut      = startHit ? cmpReg : activeLimit;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(OFS_LIMIT):  busRdata = 32'(cmpReg);
      ADDR_W'(OFS_COUNT):  busRdata = 32'(countIn);
      ADDR_W'(OFS_STATUS): busRdata[TRIG_BIT] = runReg;
      ADDR_W'(OFS_MODE):   busRdata[MODE_BIT] = modeReg;
      default:             busRdata = '0;
    endcase
  end

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    startHit |=> runReg);  // R2
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (stopHit && !startHit) |=> !runReg);  // R3
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (runReg && !startHit) |=> ($stable(activeLimit) && $stable(activeFree)));  // R9

endmodule

// File: rtl/tmr_dpath.sv
module tmr_dpath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             irq
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cntNext;
  logic             irqNext;

  always_comb begin
    cntNext = count;
    irqNext = 1'b0;
    if (st.startPulse) begin
      cntNext = st.freeMode ? '0 : limit;
    end else if (st.advance) begin
      if (st.freeMode) begin
        cntNext = count + 1'b1;
        irqNext = (cntNext == limit);
      end else if (count == '0) begin
        cntNext = limit;
        irqNext = 1'b1;
      end else begin
        cntNext = count - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      irq   <= 1'b0;
    end else begin
      count <= cntNext;
      irq   <= irqNext;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!st.advance && !st.startPulse) |=> ($stable(count) && !irq));  // R8
  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(st.advance));  // R11
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (st.advance && st.freeMode && count == CNT_MAX) |=> (count == '0));  // R7
  AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (st.advance && !st.freeMode && count == '0) |=> (irq && count == $past(limit)));  // R5

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              tickEn,
  output logic              irq
);

  strobe_t          st;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] count;

  tmr_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .tickEn   (tickEn),
    .countIn  (count),
    .st       (st),
    .limitOut (limit)
  );

  tmr_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk   (clk),
    .rstN  (rstN),
    .st    (st),
    .limit (limit),
    .count (count),
    .irq   (irq)
  );

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    st.startPulse |=> (count == ($past(st.freeMode) ? '0 : $past(limit))));  // R4 R6

endmodule

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;
  localparam int CW = 16;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic          busWrite = 1'b0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic          tickEn = 1'b0;
  logic          irq;

  always #2 clk = ~clk;

  tick_timer #(.CNT_W(CW), .ADDR_W(AW)) u_tick_timer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .tickEn(tickEn), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  int irqSeen = 0;
  bit finished = 0;

  // reference state derived from the requirements
  logic [CW-1:0] mCnt = '0, mCmp = '0, mLim = '0;
  logic mRun = 0, mCtl = 0, mFree = 0, mIrq = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks enter and leave at a falling edge
  task automatic busWr(input int addr, input logic [31:0] data);
    busAddr = AW'(addr); busWdata = data; busWrite = 1'b1; tickEn = 1'b0;
    @(posedge clk);
    mIrq = 0;
    case (addr)
      'h00: mCmp = data[CW-1:0];
      'h20: mCtl = data[1];
      'h14: if (data[0]) begin
              mRun = 1; mLim = mCmp; mFree = mCtl; mCnt = mCtl ? '0 : mCmp;
            end
      'h18: if (data[0]) mRun = 0;
      default: ;
    endcase
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rdReg(input int addr, output logic [31:0] val);
    busAddr = AW'(addr);
    #0.5;
    val = busRdata;
  endtask

  task automatic step(input bit t);
    busAddr = AW'('h04); busWrite = 1'b0; tickEn = t;
    @(posedge clk);
    mIrq = 0;
    if (mRun && t) begin
      if (mFree) begin
        mCnt = mCnt + 1'b1;
        mIrq = (mCnt == mLim);
      end else if (mCnt == '0) begin
        mCnt = mLim; mIrq = 1;
      end else begin
        mCnt = mCnt - 1'b1;
      end
    end
    @(negedge clk);
    tickEn = 1'b0;
    if (irq) irqSeen++;
    chk("R5 R7 R11 irq vs model", 32'(irq), 32'(mIrq));
    chk("R4 R6 R8 count vs model", busRdata, 32'(mCnt));
  endtask

  task automatic steps(input int n, input bit t);
    for (int i = 0; i < n; i++) step(t);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog all requirements actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    rdReg('h00, v); chk("R1 compare", v, 0);
    rdReg('h04, v); chk("R1 count", v, 0);
    rdReg('h10, v); chk("R1 status", v, 0);
    rdReg('h20, v); chk("R1 mode", v, 0);

    // R10 decode
    busWr('h20, 32'hFF); rdReg('h20, v); chk("R10 mode bit only", v, 32'h2);
    busWr('h20, 32'h0);  rdReg('h20, v); chk("R10 mode cleared", v, 0);
    busWr('h00, 32'h0001_2345); rdReg('h00, v); chk("R10 compare width", v, 32'h2345);
    rdReg('h14, v); chk("R10 start reads 0", v, 0);
    rdReg('h18, v); chk("R10 stop reads 0", v, 0);
    rdReg('h08, v); chk("R10 unmapped reads 0", v, 0);

    // R2 start trigger
    busWr('h00, 3);
    busWr('h14, 32'h2); rdReg('h10, v); chk("R2 bit0 clear ignored", v, 0);
    busWr('h14, 32'h1); rdReg('h10, v); chk("R2 running", v, 1);
    rdReg('h04, v); chk("R4 loaded with compare", v, 3);

    // R5 period of compare+1
    irqSeen = 0; steps(12, 1);
    chk("R5 irq count over 12 ticks", irqSeen, 3);
    rdReg('h10, v); chk("R5 still running", v, 1);

    // R8 no tick holds
    irqSeen = 0; steps(5, 0);
    rdReg('h04, v); chk("R8 count held", v, 3);
    chk("R8 no irq", irqSeen, 0);

    // R9 rewrites while running are deferred
    busWr('h00, 9); busWr('h20, 32'h2);
    rdReg('h00, v); chk("R9 compare readback", v, 9);
    rdReg('h20, v); chk("R9 mode readback", v, 2);
    irqSeen = 0; steps(8, 1);
    chk("R9 old period kept", irqSeen, 2);
    rdReg('h04, v); chk("R9 still down-counting", v, 3);

    // R3 stop, R11 quiet while stopped
    busWr('h18, 32'h1);
    rdReg('h10, v); chk("R3 stopped", v, 0);
    irqSeen = 0; steps(6, 1);
    rdReg('h04, v); chk("R3 count held after stop", v, 3);
    chk("R11 no irq while stopped", irqSeen, 0);

    // R6 / R7 free-running (mode already 1)
    busWr('h00, 5); busWr('h14, 32'h1);
    rdReg('h04, v); chk("R6 cleared on start", v, 0);
    irqSeen = 0; steps(10, 1);
    rdReg('h04, v); chk("R6 count up", v, 10);
    chk("R7 single match", irqSeen, 1);

    // R7 wrap
    busWr('h14, 32'h1);
    irqSeen = 0; steps(65542, 1);
    chk("R7 two matches across wrap", irqSeen, 2);
    rdReg('h04, v); chk("R7 count after wrap", v, 6);

    // constrained random mix
    for (int r = 0; r < 40; r++) begin
      busWr('h00, $urandom % 10);
      busWr('h20, ($urandom % 2) << 1);
      busWr('h14, 32'h1);
      for (int j = 0; j < 50; j++) begin
        int sel;
        sel = $urandom % 20;
        if (sel == 0)      busWr('h00, $urandom % 10);
        else if (sel == 1) busWr('h18, 32'h1);
        else if (sel == 2) busWr('h14, 32'h1);
        else if (sel == 3) busWr('h20, ($urandom % 2) << 1);
        else               step(($urandom % 3) != 0);
      end
      rdReg('h10, v); chk("R2 R3 status vs model", v, 32'(mRun));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule